// File: doc/BRIEF.md
# Soft-Stepped Stereo Digital Volume

This block scales a stereo stream of 24-bit signed samples by a digital gain set in half-dB units. Each channel has its own target gain code, and a link control lets both channels follow a single code. The gain that is actually applied never jumps. On each frame strobe it moves one half-dB code toward the current effective target. The pace is selectable: every frame, every second frame, or immediate, where the target is taken at the next strobe.

Each channel has a power request. While the request is high, the effective target is the programmed code. While it is low, the effective target is mute (code -127). A channel therefore ramps up from mute after its request rises, and ramps down to mute after the request falls. Once a lowered channel reaches mute it raises its off flag, and the channel may then be switched off. The applied code is turned into a linear factor inside the block. A 12-entry table covers one 6 dB octave, and an arithmetic shift accounts for each whole octave. The product saturates to 24 bits.

Top module: `svol_top`

## Requirements
- R1: During and after reset, before the first strobe: left_o and right_o are 0, valid_o is 0, and both applied codes are mute (-127). With the power requests low, done_l_o, done_r_o, off_l_o and off_r_o all read 1.
- R2: Output sample mapping. For applied code c (signed 8-bit, half-dB):
  - Let u = c + 144, octave o = u / 12 and index k = u % 12.
  - The output is floor(x * M[k] / 2^(26 - o)), where M[k] = round(16384 * 2^(k/12)).
  - Code 0 is therefore unity and code 48 is x16.
  - Code -127 is mute and gives 0.
- R3: Any result above 8388607 is output as 8388607, and any result below -8388608 is output as -8388608.
- R4: The applied code changes only on a cycle where frame_i is 1. When stepping, it changes by exactly one code toward the effective target.
- R5: The pace is set by rate_i:
  - 0 steps on every strobe.
  - 1 steps only on strobes where an internal phase bit is 0. The bit is 0 after reset and toggles on every strobe, whatever the rate.
  - 2 or 3 loads the effective target in full at the next strobe.
- R6: done_l_o and done_r_o are 1 exactly when the channel's applied code equals its effective target, and 0 while it still differs.
- R7: link_i selects the target source:
  - 0 or 3: independent, left uses tgt_l_i and right uses tgt_r_i.
  - 1: both channels use tgt_l_i.
  - 2: both channels use tgt_r_i.
- R8: Power requests:
  - The effective target is the selected code while a channel's pwr request is 1, and mute while it is 0.
  - off_l_o and off_r_o are 1 exactly when the request is 0 and the applied code is mute.
- R9: Target codes above 48 act as 48, and code -128 acts as -127.
- R10: The outputs are registered on a strobe edge, using the applied code from before that edge's step. valid_o is 1 for the single cycle after each strobe and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame strobe, marks a valid sample pair |
| left_i | input | 24 | Left input sample, signed |
| right_i | input | 24 | Right input sample, signed |
| tgt_l_i | input | 8 | Left target code, signed half-dB |
| tgt_r_i | input | 8 | Right target code, signed half-dB |
| link_i | input | 2 | Target link mode |
| rate_i | input | 2 | Step pace: 0 every frame, 1 every second frame, 2/3 immediate |
| pwr_l_i | input | 1 | Left power request |
| pwr_r_i | input | 1 | Right power request |
| left_o | output | 24 | Left scaled sample |
| right_o | output | 24 | Right scaled sample |
| valid_o | output | 1 | Output sample pair valid |
| done_l_o | output | 1 | Left applied code equals effective target |
| done_r_o | output | 1 | Right applied code equals effective target |
| off_l_o | output | 1 | Left at mute with power request low |
| off_r_o | output | 1 | Right at mute with power request low |

## Verification
The bench ramps full span from mute to +24 dB and back. A stepper that skips codes or overshoots shows up as scaled samples at a wrong octave or table index. The two-frame pace is checked across changes in rate. A design that resets its phase bit when the rate changes steps on the wrong strobe. Targets out of range, full-scale samples at +24 dB and link switching in the middle of a ramp are all aimed at. These expose a missing clamp as a ramp that never finishes, a missing saturation as wrapped signs, and a wrong link decode as a channel steering toward the other channel's code. Power-down checks that the off flag rises only on the strobe that lands on mute.

// File: rtl/svol_pkg.sv
package svol_pkg;
  localparam int SAMPLE_W   = 24;
  localparam int CODE_W     = 8;
  localparam int MANT_W     = 16;
  localparam int CODE_MAX   = 48;
  localparam int CODE_MUTE  = -127;
  localparam int OCT_STEPS  = 12;
  localparam int CODE_OFS   = 144;
  localparam int FRAC_BITS  = 14;
  localparam int SHIFT_BASE = FRAC_BITS + CODE_OFS / OCT_STEPS;
  localparam int NCH        = 2;

  typedef logic signed [CODE_W-1:0]   code_t;
  typedef logic signed [SAMPLE_W-1:0] smp_t;

  // fractional gain 2^(k/12) in Q2.14
  function automatic logic [MANT_W-1:0] mant_lut(input int k);
    case (k)
      0:  return 16'd16384;
      1:  return 16'd17358;
      2:  return 16'd18390;
      3:  return 16'd19484;
      4:  return 16'd20643;
      5:  return 16'd21870;
      6:  return 16'd23170;
      7:  return 16'd24548;
      8:  return 16'd26008;
      9:  return 16'd27554;
      10: return 16'd29193;
      11: return 16'd30929;
      default: return 16'd16384;
    endcase
  endfunction

  function automatic code_t clamp_code(input code_t c);
    if (int'(c) > CODE_MAX)  return code_t'(CODE_MAX);
    if (int'(c) < CODE_MUTE) return code_t'(CODE_MUTE);
    return c;
  endfunction
endpackage

// File: rtl/svol_pace.sv
module svol_pace (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_i,
  input  logic [1:0] rate_i,
  output logic       tick_o,
  output logic       imm_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ph_q <= 1'b0;
    else if (frame_i) ph_q <= ~ph_q;
  end

  assign imm_o  = rate_i[1];
  assign tick_o = frame_i & ~rate_i[1] & (~rate_i[0] | ~ph_q);
endmodule

// File: rtl/svol_step.sv
module svol_step import svol_pkg::*; (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  frame_i,
  input  logic  tick_i,
  input  logic  imm_i,
  input  code_t tgt_i,
  output code_t g_o
);
  code_t g_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) g_q <= code_t'(CODE_MUTE);
    else if (imm_i && frame_i) g_q <= tgt_i;
    else if (tick_i) begin
      if (g_q < tgt_i)      g_q <= g_q + code_t'(1);
      else if (g_q > tgt_i) g_q <= g_q - code_t'(1);
    end
  end

  assign g_o = g_q;

  // R4
  hold_off_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(g_q));

  // R4
  step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !imm_i && g_q < tgt_i) |=> (g_q == $past(g_q) + code_t'(1)));

  // R4
  step_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !imm_i && g_q > tgt_i) |=> (g_q == $past(g_q) - code_t'(1)));

  // R9
  code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g_q >= code_t'(CODE_MUTE)) && (g_q <= code_t'(CODE_MAX)));
endmodule

// File: rtl/svol_gain.sv
module svol_gain import svol_pkg::*; (
  input  code_t code_i,
  input  smp_t  smp_i,
  output smp_t  smp_o
);
  localparam int PROD_W = SAMPLE_W + MANT_W + 1;
  localparam logic signed [PROD_W-1:0] SMAX = PROD_W'((2 ** (SAMPLE_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] SMIN = -SMAX - PROD_W'(1);

  int ui, oct, idx, sh;
  logic [MANT_W-1:0] mant;
  logic signed [PROD_W-1:0] prod, scaled;

  always_comb begin
    ui   = int'(code_i) + CODE_OFS;
    oct  = ui / OCT_STEPS;
    idx  = ui % OCT_STEPS;
    sh   = SHIFT_BASE - oct;
    mant = mant_lut(idx);
    prod = PROD_W'(smp_i) * PROD_W'($signed({1'b0, mant}));
    scaled = prod >>> sh;
    if (code_i == code_t'(CODE_MUTE)) smp_o = '0;
    else if (scaled > SMAX)           smp_o = smp_t'(SMAX);
    else if (scaled < SMIN)           smp_o = smp_t'(SMIN);
    else                              smp_o = smp_t'(scaled);
  end
endmodule

// File: rtl/svol_top.sv
module svol_top import svol_pkg::*; (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic [CODE_W-1:0]   tgt_l_i,
  input  logic [CODE_W-1:0]   tgt_r_i,
  input  logic [1:0]          link_i,
  input  logic [1:0]          rate_i,
  input  logic                pwr_l_i,
  input  logic                pwr_r_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o,
  output logic                done_l_o,
  output logic                done_r_o,
  output logic                off_l_o,
  output logic                off_r_o
);
  logic tick, imm;
  code_t tgt_sel [NCH];
  code_t eff     [NCH];
  code_t g       [NCH];
  smp_t  smp_in  [NCH];
  smp_t  smp_sc  [NCH];
  smp_t  smp_q   [NCH];
  logic  pwr     [NCH];
  logic  valid_q;

  assign smp_in[0] = smp_t'(left_i);
  assign smp_in[1] = smp_t'(right_i);
  assign pwr[0]    = pwr_l_i;
  assign pwr[1]    = pwr_r_i;

  // R7
  always_comb begin
    case (link_i)
      2'd1:    begin tgt_sel[0] = code_t'(tgt_l_i); tgt_sel[1] = code_t'(tgt_l_i); end
      2'd2:    begin tgt_sel[0] = code_t'(tgt_r_i); tgt_sel[1] = code_t'(tgt_r_i); end
      default: begin tgt_sel[0] = code_t'(tgt_l_i); tgt_sel[1] = code_t'(tgt_r_i); end
    endcase
  end

  svol_pace u_pace (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .frame_i(frame_i),
    .rate_i (rate_i),
    .tick_o (tick),
    .imm_o  (imm)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign eff[c] = pwr[c] ? clamp_code(tgt_sel[c]) : code_t'(CODE_MUTE);

    svol_step u_step (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .frame_i(frame_i),
      .tick_i (tick),
      .imm_i  (imm),
      .tgt_i  (eff[c]),
      .g_o    (g[c])
    );

    svol_gain u_gain (
      .code_i(g[c]),
      .smp_i (smp_in[c]),
      .smp_o (smp_sc[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      smp_q[c] <= '0;
      else if (frame_i) smp_q[c] <= smp_sc[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= frame_i;
  end

  assign left_o   = smp_q[0];
  assign right_o  = smp_q[1];
  assign valid_o  = valid_q;
  assign done_l_o = (g[0] == eff[0]);
  assign done_r_o = (g[1] == eff[1]);
  assign off_l_o  = ~pwr_l_i & (g[0] == code_t'(CODE_MUTE));
  assign off_r_o  = ~pwr_r_i & (g[1] == code_t'(CODE_MUTE));

  // R10
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> ($stable(left_o) && $stable(right_o)));
endmodule

// File: tb/tb_svol_top.sv
`timescale 1ns/1ps
module tb_svol_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frame = 1'b0;
  logic [23:0] left_in = '0, right_in = '0;
  logic [7:0] tgt_l = '0, tgt_r = '0;
  logic [1:0] link = '0, rate = '0;
  logic pwr_l = 1'b0, pwr_r = 1'b0;
  logic [23:0] left_out, right_out;
  logic valid, done_l, done_r, off_l, off_r;

  int n_chk = 0, n_fail = 0;
  int gm [2];
  int ph = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  svol_top dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .left_i(left_in), .right_i(right_in),
    .tgt_l_i(tgt_l), .tgt_r_i(tgt_r), .link_i(link), .rate_i(rate),
    .pwr_l_i(pwr_l), .pwr_r_i(pwr_r), .left_o(left_out), .right_o(right_out),
    .valid_o(valid), .done_l_o(done_l), .done_r_o(done_r), .off_l_o(off_l), .off_r_o(off_r)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic int mant(input int k);
    return $rtoi(16384.0 * (2.0 ** (real'(k) / 12.0)) + 0.5);
  endfunction

  function automatic longint gain_ref(input longint x, input int c);
    longint p;
    int u;
    if (c == -127) return 0;
    u = c + 144;
    p = (x * mant(u % 12)) >>> (26 - u / 12);
    if (p > 8388607)  return 8388607;
    if (p < -8388608) return -8388608;
    return p;
  endfunction

  function automatic int clampc(input int c);
    if (c > 48)   return 48;
    if (c < -127) return -127;
    return c;
  endfunction

  function automatic int eff_ref(input int ch);
    int sel;
    logic p;
    p = (ch == 0) ? pwr_l : pwr_r;
    if (link == 2'd1)      sel = $signed(tgt_l);
    else if (link == 2'd2) sel = $signed(tgt_r);
    else                   sel = (ch == 0) ? $signed(tgt_l) : $signed(tgt_r);
    return p ? clampc(sel) : -127;
  endfunction

  task automatic check_flags();
    chk("R6 done_l", done_l, gm[0] == eff_ref(0));
    chk("R6 done_r", done_r, gm[1] == eff_ref(1));
    chk("R8 off_l", off_l, !pwr_l && gm[0] == -127);
    chk("R8 off_r", off_r, !pwr_r && gm[1] == -127);
  endtask

  // drive one strobe at a negedge, check one cycle later at the next negedge
  task automatic do_frame(input logic [23:0] xl, input logic [23:0] xr, input bit gap);
    longint el, er;
    bit tick;
    int e;
    left_in = xl; right_in = xr; frame = 1'b1;
    el = gain_ref(longint'($signed(xl)), gm[0]);
    er = gain_ref(longint'($signed(xr)), gm[1]);
    tick = (rate == 2'd0) || (rate == 2'd1 && ph == 0);
    ph = ph ^ 1;
    for (int c = 0; c < 2; c++) begin
      e = eff_ref(c);
      if (rate[1]) gm[c] = e;
      else if (tick) begin
        if (gm[c] < e) gm[c]++;
        else if (gm[c] > e) gm[c]--;
      end
    end
    @(negedge clk);
    frame = 1'b0;
    chk("R2 left", longint'($signed(left_out)), el);
    chk("R2 right", longint'($signed(right_out)), er);
    chk("R10 valid", valid, 1);
    check_flags();
    if (gap) begin
      left_in = 24'($urandom);
      @(negedge clk);
      chk("R10 valid idle", valid, 0);
      chk("R10 hold left", longint'($signed(left_out)), el);
    end
  endtask

  function automatic logic [23:0] rnd();
    return 24'($urandom);
  endfunction

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    gm[0] = -127; gm[1] = -127;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 left", left_out, 0);
    chk("R1 valid", valid, 0);
    check_flags();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 right after reset", right_out, 0);
    check_flags();

    // R8 power up ramp, R4 step per frame, R5 rate 0
    pwr_l = 1; pwr_r = 1; tgt_l = 8'd0; tgt_r = 8'($signed(-20));
    @(negedge clk);
    chk("R6 done_l before ramp", done_l, 0);
    for (int i = 0; i < 135; i++) do_frame(rnd(), rnd(), i % 7 == 0);

    // R3 saturation at +24 dB
    tgt_l = 8'd48; tgt_r = 8'd48; rate = 2'd2;
    do_frame(24'h7FFFFF, 24'h800000, 0);
    do_frame(24'h7FFFFF, 24'h800000, 0);
    chk("R3 pos sat", longint'($signed(left_out)), 8388607);
    chk("R3 neg sat", longint'($signed(right_out)), -8388608);
    for (int i = 0; i < 4; i++) do_frame(rnd(), rnd(), 0);

    // R5 rate 1, toggled phase
    rate = 2'd1; tgt_l = 8'($signed(-60)); tgt_r = 8'd5;
    for (int i = 0; i < 60; i++) do_frame(rnd(), rnd(), i % 5 == 0);
    rate = 2'd0;
    do_frame(rnd(), rnd(), 0);
    rate = 2'd1;
    for (int i = 0; i < 20; i++) do_frame(rnd(), rnd(), 0);

    // R5 immediate
    rate = 2'd3; tgt_l = 8'd10; tgt_r = 8'($signed(-100));
    do_frame(rnd(), rnd(), 1);
    do_frame(rnd(), rnd(), 0);

    // R7 link modes
    rate = 2'd0; link = 2'd1; tgt_l = 8'd2; tgt_r = 8'd30;
    for (int i = 0; i < 40; i++) do_frame(rnd(), rnd(), 0);
    link = 2'd2;
    for (int i = 0; i < 40; i++) do_frame(rnd(), rnd(), 0);
    link = 2'd3;
    for (int i = 0; i < 40; i++) do_frame(rnd(), rnd(), 0);

    // R9 clamp of out-of-range targets
    link = 2'd0; tgt_l = 8'h7F; tgt_r = 8'h80; rate = 2'd2;
    do_frame(rnd(), rnd(), 0);
    do_frame(rnd(), rnd(), 0);
    chk("R9 clamp hi done", done_l, 1);
    chk("R9 clamp lo done", done_r, 1);
    rate = 2'd0;
    for (int i = 0; i < 10; i++) do_frame(rnd(), rnd(), 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      if (i % 40 == 0) begin
        tgt_l = 8'($urandom); tgt_r = 8'($urandom);
        link = 2'($urandom); rate = 2'($urandom_range(0, 4) == 4 ? 2 : $urandom_range(0, 1));
        pwr_l = ($urandom_range(0, 3) != 0); pwr_r = ($urandom_range(0, 3) != 0);
      end
      do_frame(rnd(), rnd(), $urandom_range(0, 9) == 0);
    end

    // R8 power down ramp to mute
    pwr_l = 1; pwr_r = 1; rate = 2'd2; tgt_l = 8'd20; tgt_r = 8'd0; link = 2'd0;
    do_frame(rnd(), rnd(), 0);
    rate = 2'd0; pwr_l = 0; pwr_r = 0;
    @(negedge clk);
    chk("R8 off_l early", off_l, 0);
    for (int i = 0; i < 150; i++) do_frame(rnd(), rnd(), 0);
    chk("R8 off_l final", off_l, 1);
    chk("R8 off_r final", off_r, 1);
    do_frame(24'h123456, 24'h654321, 0);
    chk("R2 mute left", left_out, 0);
    summary();
  end
endmodule